// File: doc/BRIEF.md
# Factory Invalid-Block Table Builder

This block runs once after power-up, ahead of any normal use of a page-organized NAND array. It visits every erase block in ascending order and reads the factory marker byte, at spare column 517, from the block's first page. When that byte is FFh it also reads the same column from the second page. Any marker that is not FFh marks the block as invalid in a one-bit-per-block table. Block 0 is always recorded as valid, whatever its markers hold.

The block sends byte reads to a NAND host interface through a simple request port. The port carries a page row address, a column and a request flag. The host answers with a ready pulse and the data byte in that same cycle. When the walk ends, the block raises a done flag and presents the number of invalid blocks. Software or a later mapping stage then reads the table by block number through a read port with one cycle of latency.

Top module: `bbt_scan_top`

## Requirements
- R1: After reset, `done_o`, `busy_o` and `rd_req_o` are 0 and `bad_count_o` is 0.
- R2: A `start_i` pulse while idle sets `busy_o` on the next cycle. The block then visits blocks 0 up to NUM_BLOCKS-1 in ascending order. The first read of each block uses row = block*16 + 0, that is, the block number in the row's upper bits and page index 0 in its low 4 bits. Every read uses column 517, which is spare base 512 plus offset 5.
- R3: The second read of a block (row = block*16 + 1) is issued only when the page-0 byte was FFh. Otherwise the scan moves straight to the next block's page-0 read.
- R4: A block is invalid when its page-0 byte, or its page-1 byte, is not FFh. `tbl_bad_o` gives the entry for `tbl_idx_i` one clock after it is applied, with 1 meaning invalid and 0 meaning valid.
- R5: The table entry for block 0 is always 0, even when both of its marker bytes are not FFh.
- R6: `rd_req_o` stays high with a stable `rd_row_o` until the cycle in which `rd_ack_i` is high. `rd_data_i` is taken in that cycle.
- R7: After the last block's final read, `done_o` goes to 1, `busy_o` to 0, and `bad_count_o` equals the number of invalid blocks. Both values hold until the next start.
- R8: A `start_i` pulse while `busy_o` is 1 has no effect, and the scan in progress continues unchanged.
- R9: Each accepted start clears the whole table to valid and sets the count to 0 before the new scan begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a scan (taken only when idle) |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Last scan finished; held until next start |
| bad_count_o | output | 10 | Number of invalid blocks found |
| rd_req_o | output | 1 | Byte read request to host interface |
| rd_row_o | output | 13 | Page row address: block*16 + page |
| rd_col_o | output | 10 | Column address of the byte (517) |
| rd_ack_i | input | 1 | Host ready; data valid this cycle |
| rd_data_i | input | 8 | Byte returned by the host |
| tbl_idx_i | input | 9 | Block number to look up |
| tbl_bad_o | output | 1 | Table entry for previous `tbl_idx_i`; 1 = invalid |

## Verification
Four marker patterns are used. The first is an all-erased array, which shows that every block gets a page-1 read and that nothing is flagged. The second flags blocks through page-0 markers on one residue class and page-1 markers on another, with block 0 carrying bad markers in both pages. This pattern separates the skip-on-bad-page-0 path from the two-read path and shows the block-0 override. The third pattern is a different mix, and a stray start arrives in the middle of that scan. A final all-erased scan following a marked scan shows whether a start clears leftover table bits and the count. The host model answers with a latency that depends on the row, so a request is held for 0 to 2 extra cycles. Every request is compared in order against a queue of expected rows.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PG0  = 2'd1,
    S_PG1  = 2'd2
  } scan_st_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/bbt_seq.sv
module bbt_seq
  import bbt_pkg::*;
#(
  parameter int NUM_BLOCKS    = 512,
  parameter int PAGES_PER_BLK = 16,
  parameter int BLK_W         = $clog2(NUM_BLOCKS),
  parameter int PG_W          = $clog2(PAGES_PER_BLK),
  parameter int ROW_W         = BLK_W + PG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rd_ack_i,
  input  logic [7:0]       rd_data_i,
  output logic             rd_req_o,
  output logic [ROW_W-1:0] rd_row_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             clr_o,
  output logic             mark_o,
  output logic [BLK_W-1:0] mark_blk_o
);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  scan_st_t         st_q, st_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             done_q, done_d;
  logic             st_en, blk_en, done_en;
  logic             byte_bad, advance;

  assign byte_bad = (rd_data_i != ERASED_BYTE);

  always_comb begin
    st_d    = st_q;
    blk_d   = blk_q;
    done_d  = done_q;
    clr_o   = 1'b0;
    mark_o  = 1'b0;
    advance = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          clr_o  = 1'b1;
          blk_d  = '0;
          done_d = 1'b0;
          st_d   = S_PG0;
        end
      end
      S_PG0: begin
        if (rd_ack_i) begin
          if (byte_bad) begin
            mark_o  = (blk_q != '0);
            advance = 1'b1;
          end else begin
            st_d = S_PG1;
          end
        end
      end
      S_PG1: begin
        if (rd_ack_i) begin
          mark_o  = byte_bad && (blk_q != '0);
          advance = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (advance) begin
      if (blk_q == LAST_BLK) begin
        st_d   = S_IDLE;
        done_d = 1'b1;
      end else begin
        blk_d = blk_q + 1'b1;
        st_d  = S_PG0;
      end
    end
  end

  assign st_en   = (st_d != st_q);
  assign blk_en  = clr_o | advance;
  assign done_en = clr_o | advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else if (blk_en) begin
      blk_q <= blk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (done_en) begin
      done_q <= done_d;
    end
  end

  assign rd_req_o   = (st_q == S_PG0) || (st_q == S_PG1);
  assign rd_row_o   = {blk_q, PG_W'(st_q == S_PG1)};
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;
  assign mark_blk_o = blk_q;

  // R6: a pending request keeps its row until accepted
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_row_o));

  // R3: an erased page-0 marker is followed by the page-1 read of the same block
  a_r3_page1_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PG0) && rd_ack_i && !byte_bad |=> rd_req_o && (rd_row_o == $past(rd_row_o) + 1'b1));

  // R8: a start during a scan leaves the scan running
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !advance |=> busy_o && $stable(mark_blk_o));
endmodule

// File: rtl/bbt_table.sv
module bbt_table #(
  parameter int NUM_BLOCKS = 512,
  parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             mark_i,
  input  logic [BLK_W-1:0] mark_idx_i,
  input  logic [BLK_W-1:0] rd_idx_i,
  output logic             rd_bad_o
);
  logic [NUM_BLOCKS-1:0] tbl_q;
  logic [NUM_BLOCKS-1:0] set_vec;
  logic                  tbl_en;
  logic                  rd_bad_q;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_set
    assign set_vec[g] = mark_i && (mark_idx_i == BLK_W'(g));
  end

  assign tbl_en = clr_i | mark_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q <= '0;
    end else if (tbl_en) begin
      tbl_q <= clr_i ? '0 : (tbl_q | set_vec);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bad_q <= 1'b0;
    end else begin
      rd_bad_q <= tbl_q[rd_idx_i];
    end
  end

  assign rd_bad_o = rd_bad_q;

  // R5: the sequencer never requests a mark for block 0
  a_r5_blk0_never_marked: assert property (@(posedge clk) disable iff (!rst_n)
    mark_i |-> (mark_idx_i != '0));

  // R9: clearing and marking never coincide
  a_r9_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> !mark_i);
endmodule

// File: rtl/bbt_tally.sv
module bbt_tally #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr_i | inc_i;
  assign cnt_d  = clr_i ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

  // R9: an accepted start zeroes the count
  a_r9_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0));

  // R7: every new mark adds exactly one
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i && !clr_i |=> (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/bbt_scan_top.sv
module bbt_scan_top #(
  parameter int NUM_BLOCKS    = 512,
  parameter int PAGES_PER_BLK = 16,
  parameter int MAIN_BYTES    = 512,
  parameter int SPARE_BYTES   = 16,
  parameter int MARK_OFS      = 5,
  parameter int BLK_W         = $clog2(NUM_BLOCKS),
  parameter int PG_W          = $clog2(PAGES_PER_BLK),
  parameter int ROW_W         = BLK_W + PG_W,
  parameter int COL_W         = $clog2(MAIN_BYTES + SPARE_BYTES),
  parameter int CNT_W         = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] bad_count_o,
  output logic             rd_req_o,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [COL_W-1:0] rd_col_o,
  input  logic             rd_ack_i,
  input  logic [7:0]       rd_data_i,
  input  logic [BLK_W-1:0] tbl_idx_i,
  output logic             tbl_bad_o
);
  localparam logic [COL_W-1:0] MARK_COL = COL_W'(MAIN_BYTES + MARK_OFS);

  logic             clr;
  logic             mark;
  logic [BLK_W-1:0] mark_blk;

  bbt_seq #(
    .NUM_BLOCKS   (NUM_BLOCKS),
    .PAGES_PER_BLK(PAGES_PER_BLK),
    .BLK_W        (BLK_W),
    .PG_W         (PG_W),
    .ROW_W        (ROW_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rd_ack_i  (rd_ack_i),
    .rd_data_i (rd_data_i),
    .rd_req_o  (rd_req_o),
    .rd_row_o  (rd_row_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .clr_o     (clr),
    .mark_o    (mark),
    .mark_blk_o(mark_blk)
  );

  bbt_table #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .BLK_W     (BLK_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr),
    .mark_i    (mark),
    .mark_idx_i(mark_blk),
    .rd_idx_i  (tbl_idx_i),
    .rd_bad_o  (tbl_bad_o)
  );

  bbt_tally #(
    .CNT_W(CNT_W)
  ) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .inc_i  (mark),
    .count_o(bad_count_o)
  );

  assign rd_col_o = MARK_COL;

  // R7: done and busy are never both set
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R7: a finished result holds until the next start
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(bad_count_o));
endmodule

// File: tb/test_bbt_scan_top.sv
module test_bbt_scan_top;
  localparam int NB  = 512;
  localparam int PPB = 16;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       busy_o, done_o;
  logic [9:0] bad_count_o;
  logic       rd_req_o;
  logic [12:0] rd_row_o;
  logic [9:0] rd_col_o;
  logic       rd_ack_i;
  logic [7:0] rd_data_i;
  logic [8:0] tbl_idx_i;
  logic       tbl_bad_o;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  int mode = 0;
  int wt = 0;
  int cyc = 0;

  bbt_scan_top i_bbt_scan_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .bad_count_o(bad_count_o), .rd_req_o(rd_req_o), .rd_row_o(rd_row_o),
    .rd_col_o(rd_col_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .tbl_idx_i(tbl_idx_i), .tbl_bad_o(tbl_bad_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] mark_byte(int m, int b, int pg);
    if (m == 1) begin
      if (b == 0) return 8'h00;
      if (pg == 0 && (b % 7) == 3) return 8'hFE;
      if (pg == 1 && (b % 11) == 5) return 8'h7F;
    end else if (m == 2) begin
      if (pg == 0 && (b % 4) == 2) return 8'h3C;
      if (pg == 1 && (b % 2) == 1) return 8'h00;
    end
    return 8'hFF;
  endfunction

  function automatic bit exp_bad(int m, int b);
    return (b != 0) && ((mark_byte(m, b, 0) != 8'hFF) || (mark_byte(m, b, 1) != 8'hFF));
  endfunction

  function automatic int exp_count(int m);
    int c = 0;
    for (int b = 0; b < NB; b++) if (exp_bad(m, b)) c++;
    return c;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push_expect(int m);
    exp_q.delete();
    for (int b = 0; b < NB; b++) begin
      exp_q.push_back(b * PPB);
      if (mark_byte(m, b, 0) == 8'hFF) exp_q.push_back(b * PPB + 1);
    end
  endtask

  // host model and monitor: pops the expected row on each answered request
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ack_i  = 1'b0;
      rd_data_i = 8'h00;
      wt        = 0;
    end else if (rd_ack_i) begin
      rd_ack_i = 1'b0;
      wt       = 0;
    end else if (rd_req_o) begin
      if (wt >= (int'(rd_row_o) % 3)) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected read row", int'(rd_row_o), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          // R2 ordering / R3 page-1 only after an erased page-0 marker
          check(int'(rd_row_o) == e, "R3", "read row order", int'(rd_row_o), e);
        end
        check(rd_col_o == 10'd517, "R2", "read column", int'(rd_col_o), 517);
        rd_data_i = mark_byte(mode, int'(rd_row_o) / PPB, int'(rd_row_o) % PPB);
        rd_ack_i  = 1'b1;
      end else begin
        wt++;
      end
    end
  end

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, 150000);
      summary_and_end();
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  task automatic sweep_table(int m);
    for (int b = 0; b < NB; b++) begin
      @(negedge clk) tbl_idx_i = 9'(b);
      @(negedge clk);
      if (b == 0) check(tbl_bad_o == 1'b0, "R5", "block 0 entry", int'(tbl_bad_o), 0);
      else check(tbl_bad_o == exp_bad(m, b), "R4", $sformatf("entry of block %0d", b),
                 int'(tbl_bad_o), int'(exp_bad(m, b)));
    end
  endtask

  task automatic finish_checks(int m, string tag);
    check(exp_q.size() == 0, "R2", {tag, " reads left over"}, exp_q.size(), 0);
    check(busy_o == 1'b0, "R7", {tag, " busy at end"}, int'(busy_o), 0);
    check(int'(bad_count_o) == exp_count(m), "R7", {tag, " invalid count"},
          int'(bad_count_o), exp_count(m));
    sweep_table(m);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; tbl_idx_i = '0;
    repeat (3) @(negedge clk);
    check(done_o == 0, "R1", "done after reset", int'(done_o), 0);
    check(busy_o == 0, "R1", "busy after reset", int'(busy_o), 0);
    check(rd_req_o == 0, "R1", "request after reset", int'(rd_req_o), 0);
    check(bad_count_o == 0, "R1", "count after reset", int'(bad_count_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // all-erased array
    mode = 0; push_expect(0);
    pulse_start();
    check(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
    wait_done();
    finish_checks(0, "erased");

    // mixed markers, block 0 marked in both pages
    mode = 1; push_expect(1);
    pulse_start();
    check(done_o == 1'b0, "R7", "done cleared by start", int'(done_o), 0);
    wait_done();
    finish_checks(1, "mixed");
    repeat (20) @(negedge clk);
    check(done_o == 1'b1, "R7", "done held", int'(done_o), 1);
    check(int'(bad_count_o) == exp_count(1), "R7", "count held", int'(bad_count_o), exp_count(1));

    // second pattern with a stray start mid-scan
    mode = 2; push_expect(2);
    pulse_start();
    repeat (300) @(negedge clk);
    check(busy_o == 1'b1, "R8", "busy before stray start", int'(busy_o), 1);
    pulse_start();
    check(busy_o == 1'b1, "R8", "busy after stray start", int'(busy_o), 1);
    wait_done();
    finish_checks(2, "stray-start R8");

    // erased scan after a marked scan: table and count must be cleared
    mode = 0; push_expect(0);
    pulse_start();
    check(bad_count_o == 0, "R9", "count after restart", int'(bad_count_o), 0);
    wait_done();
    finish_checks(0, "rescan R9");

    summary_and_end();
  end
endmodule